// File: doc/BRIEF.md
# Loopback and All-Ones Transmit Selector

This block sits between the system-side transmit and receive ports of a line interface and the line-side encoder and decoder paths. In normal operation it sends system transmit rails to the line and passes recovered rails to the receive outputs. It also provides three maintenance paths:

- Remote loopback returns recovered data to the line at the recovered rate.
- Local loopback turns system transmit data and its clock around to the receive side.
- Transmit-all-ones replaces line data with alternating AMI marks at the transmit rate.

All-ones stays on the line during either loopback. The loopback path to the receive outputs carries on independently.

Everything runs on one core clock, with two clock enables: one marks transmit bit slots and one marks recovered bit slots. Each side has a registered rate/clock select that names which enable times it. A side loads its next bit, and any new routing, only on a slot of the enable it currently follows, so no partial bit is ever emitted.

Asserting both loopback controls is not a legal combination. If it happens, local loopback wins and a sticky flag records the misuse until reset.

Top module: `lbk_ones_selector`

## Requirements
- R1: While reset is high, and on the first cycle after it, all outputs are 0. This covers the line rails, `line_rate_sel`, the receive rails, `rcv_clk_sel` and `loop_conflict`. The all-ones polarity also restarts at positive.
- R2: With no loopback and no all-ones, these updates happen after the strobe edge and nothing else changes:
  - On a line strobe, the line rails take the transmit rails and `line_rate_sel` becomes 0 (transmit rate).
  - On a receive strobe, the receive rails take the recovered rails and `rcv_clk_sel` becomes 0 (recovered clock).
- R3: In remote loopback (remote high, local low, all-ones low), a line strobe loads the recovered rails onto the line and sets `line_rate_sel` to 1 (recovered rate). Transmit rails have no effect on the line. The receive side keeps carrying recovered data.
- R4: In local loopback without all-ones, a receive strobe loads the transmit rails onto the receive rails and sets `rcv_clk_sel` to 1 (transmit clock). The line keeps carrying transmit rails at the transmit rate.
- R5: With all-ones high, each line strobe emits one AMI mark and sets `line_rate_sel` to 0. Marks alternate between positive (pos=1, neg=0) and negative (pos=0, neg=1). The first mark after reset is positive. Transmit rails have no effect on the line.
- R6: All-ones together with local loopback puts marks on the line while the receive rails still take the transmit rails with `rcv_clk_sel` = 1.
- R7: All-ones together with remote loopback puts marks on the line at the transmit rate while the receive rails still take the recovered rails with `rcv_clk_sel` = 0.
- R8: When both loopback controls are high, local loopback routing applies. `loop_conflict` goes to 1 after that edge and stays 1 until reset.
- R9: The strobe for each side is chosen by that side's current select. The line strobe is `tx_en` when `line_rate_sel` = 0 and `rx_en` when it is 1. The receive strobe is `rx_en` when `rcv_clk_sel` = 0 and `tx_en` when it is 1. Without its strobe, a side's rails and select hold their values, whatever the data and controls do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_pos | input | 1 | System transmit positive rail |
| tx_neg | input | 1 | System transmit negative rail |
| tx_en | input | 1 | Transmit bit-slot clock enable |
| rx_pos | input | 1 | Recovered positive rail |
| rx_neg | input | 1 | Recovered negative rail |
| rx_en | input | 1 | Recovered bit-slot clock enable |
| rmt_loop | input | 1 | Remote loopback request |
| loc_loop | input | 1 | Local loopback request |
| ones_req | input | 1 | Transmit-all-ones request |
| line_pos | output | 1 | Line-side positive rail |
| line_neg | output | 1 | Line-side negative rail |
| line_rate_sel | output | 1 | Line timing: 0 transmit enable, 1 recovered enable |
| rcv_pos | output | 1 | Receive-side positive rail |
| rcv_neg | output | 1 | Receive-side negative rail |
| rcv_clk_sel | output | 1 | Receive timing: 0 recovered enable, 1 transmit enable |
| loop_conflict | output | 1 | Sticky flag: both loopbacks were requested |

## Verification
Every output is a single register stage. A strobe edge that samples the inputs shows its result straight after that edge, and the conflict flag follows the edge where both loopback controls are seen high.

The bench changes inputs on the falling clock edge and steps one rising edge. It compares all six data outputs on the next falling edge, so each comparison lands exactly one register stage after its stimulus.

Hold behaviour is tested by withholding the enable that a side currently follows while raising the other one. The check then confirms that a switch into remote loopback takes effect on the old transmit strobe and not on the recovered one.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

    typedef struct packed {
        logic pos;
        logic neg;
    } rail_t;

    typedef enum logic [1:0] {
        LSRC_SYS  = 2'd0,
        LSRC_REC  = 2'd1,
        LSRC_ONES = 2'd2
    } line_src_e;

    typedef enum logic {
        RATE_TX  = 1'b0,
        RATE_REC = 1'b1
    } rate_e;

    typedef struct packed {
        line_src_e line_src;
        rate_e     line_rate;
        logic      rcv_from_tx;
    } route_t;

    // Local loopback outranks remote loopback; all-ones only owns the line.
    function automatic route_t decode_route(input logic rmt, input logic loc,
                                            input logic ones);
        route_t r;
        r.rcv_from_tx = loc;
        if (ones) begin
            r.line_src  = LSRC_ONES;
            r.line_rate = RATE_TX;
        end else if (rmt && !loc) begin
            r.line_src  = LSRC_REC;
            r.line_rate = RATE_REC;
        end else begin
            r.line_src  = LSRC_SYS;
            r.line_rate = RATE_TX;
        end
        return r;
    endfunction

    function automatic rail_t ones_mark(input logic negative_turn);
        rail_t m;
        m.pos = ~negative_turn;
        m.neg = negative_turn;
        return m;
    endfunction

endpackage

// File: rtl/lbk_route_decode.sv
module lbk_route_decode
    import lbk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   rmt_loop,
    input  logic   loc_loop,
    input  logic   ones_req,
    output route_t route,
    output logic   conflict
);

    assign route = decode_route(rmt_loop, loc_loop, ones_req);

    always_ff @(posedge clk) begin
        if (rst) begin
            conflict <= 1'b0;
        end else if (rmt_loop && loc_loop) begin
            conflict <= 1'b1;
        end
    end

    // R8
    conflict_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rmt_loop && loc_loop) |=> conflict);

    // R8
    conflict_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        conflict |=> conflict);

endmodule

// File: rtl/lbk_line_path.sv
module lbk_line_path
    import lbk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_src_e src,
    input  rate_e     rate_next,
    input  rail_t     tx,
    input  rail_t     rx,
    input  logic      tx_en,
    input  logic      rx_en,
    output rail_t     line,
    output rate_e     rate_q
);

    logic stb;
    logic neg_turn;

    assign stb = (rate_q == RATE_REC) ? rx_en : tx_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            line     <= '0;
            rate_q   <= RATE_TX;
            neg_turn <= 1'b0;
        end else if (stb) begin
            rate_q <= rate_next;
            case (src)
                LSRC_SYS:  line <= tx;
                LSRC_REC:  line <= rx;
                LSRC_ONES: begin
                    line     <= ones_mark(neg_turn);
                    neg_turn <= ~neg_turn;
                end
                default:   line <= '0;
            endcase
        end
    end

    // R9
    line_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable({line, rate_q}));

    // R5
    ones_mark_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && src == LSRC_ONES) |=> (rate_q == RATE_TX && (line.pos ^ line.neg)));

    // R5
    ones_alternate_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && src == LSRC_ONES && $past(stb && src == LSRC_ONES) && $past(!rst))
        |=> (line != $past(line)));

    // R3
    remote_line_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && src == LSRC_REC) |=> (rate_q == RATE_REC && line == $past(rx)));

endmodule

// File: rtl/lbk_rcv_path.sv
module lbk_rcv_path
    import lbk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  from_tx,
    input  rail_t tx,
    input  rail_t rx,
    input  logic  tx_en,
    input  logic  rx_en,
    output rail_t rcv,
    output logic  clk_sel
);

    logic stb;

    assign stb = clk_sel ? tx_en : rx_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            rcv     <= '0;
            clk_sel <= 1'b0;
        end else if (stb) begin
            clk_sel <= from_tx;
            rcv     <= from_tx ? tx : rx;
        end
    end

    // R9
    rcv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable({rcv, clk_sel}));

    // R4
    local_rcv_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && from_tx) |=> (clk_sel && rcv == $past(tx)));

    // R7
    recovered_rcv_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && !from_tx) |=> (!clk_sel && rcv == $past(rx)));

endmodule

// File: rtl/lbk_ones_selector.sv
module lbk_ones_selector
    import lbk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tx_pos,
    input  logic tx_neg,
    input  logic tx_en,
    input  logic rx_pos,
    input  logic rx_neg,
    input  logic rx_en,
    input  logic rmt_loop,
    input  logic loc_loop,
    input  logic ones_req,
    output logic line_pos,
    output logic line_neg,
    output logic line_rate_sel,
    output logic rcv_pos,
    output logic rcv_neg,
    output logic rcv_clk_sel,
    output logic loop_conflict
);

    route_t route;
    rail_t  tx_rail;
    rail_t  rx_rail;
    rail_t  line_rail;
    rail_t  rcv_rail;
    rate_e  line_rate;

    assign tx_rail = '{pos: tx_pos, neg: tx_neg};
    assign rx_rail = '{pos: rx_pos, neg: rx_neg};

    lbk_route_decode u_decode (
        .clk      (clk),
        .rst      (rst),
        .rmt_loop (rmt_loop),
        .loc_loop (loc_loop),
        .ones_req (ones_req),
        .route    (route),
        .conflict (loop_conflict)
    );

    lbk_line_path u_line (
        .clk       (clk),
        .rst       (rst),
        .src       (route.line_src),
        .rate_next (route.line_rate),
        .tx        (tx_rail),
        .rx        (rx_rail),
        .tx_en     (tx_en),
        .rx_en     (rx_en),
        .line      (line_rail),
        .rate_q    (line_rate)
    );

    lbk_rcv_path u_rcv (
        .clk     (clk),
        .rst     (rst),
        .from_tx (route.rcv_from_tx),
        .tx      (tx_rail),
        .rx      (rx_rail),
        .tx_en   (tx_en),
        .rx_en   (rx_en),
        .rcv     (rcv_rail),
        .clk_sel (rcv_clk_sel)
    );

    assign line_pos      = line_rail.pos;
    assign line_neg      = line_rail.neg;
    assign line_rate_sel = (line_rate == RATE_REC);
    assign rcv_pos       = rcv_rail.pos;
    assign rcv_neg       = rcv_rail.neg;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> !(line_pos || line_neg || line_rate_sel || rcv_pos || rcv_neg
                  || rcv_clk_sel || loop_conflict));

    // R6
    ones_local_chk: assert property (@(posedge clk) disable iff (rst)
        (ones_req && loc_loop && tx_en && !line_rate_sel && rcv_clk_sel)
        |=> (rcv_clk_sel && !line_rate_sel && (line_pos ^ line_neg)));

endmodule

// File: tb/sim_lbk_ones_selector.sv
module sim_lbk_ones_selector;

    logic clk = 1'b0;
    logic rst;
    logic tx_pos, tx_neg, tx_en, rx_pos, rx_neg, rx_en;
    logic rmt_loop, loc_loop, ones_req;
    logic line_pos, line_neg, line_rate_sel, rcv_pos, rcv_neg, rcv_clk_sel;
    logic loop_conflict;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    lbk_ones_selector u0 (
        .clk(clk), .rst(rst),
        .tx_pos(tx_pos), .tx_neg(tx_neg), .tx_en(tx_en),
        .rx_pos(rx_pos), .rx_neg(rx_neg), .rx_en(rx_en),
        .rmt_loop(rmt_loop), .loc_loop(loc_loop), .ones_req(ones_req),
        .line_pos(line_pos), .line_neg(line_neg), .line_rate_sel(line_rate_sel),
        .rcv_pos(rcv_pos), .rcv_neg(rcv_neg), .rcv_clk_sel(rcv_clk_sel),
        .loop_conflict(loop_conflict)
    );

    // {rmt,loc,ones}[12:10] {txp,txn}[9:8] {rxp,rxn}[7:6]
    // expected {line_pos,line_neg,line_rate_sel,rcv_pos,rcv_neg,rcv_clk_sel}[5:0]
    localparam int NV = 11;
    localparam logic [12:0] VT [0:NV-1] = '{
        13'b000_10_01_100010,  // R2
        13'b000_01_10_010100,  // R2
        13'b100_10_01_011010,  // R3
        13'b100_00_10_101100,  // R3
        13'b010_10_01_100101,  // R4
        13'b010_01_10_010011,  // R4
        13'b001_01_01_100010,  // R5 first mark positive
        13'b001_10_10_010100,  // R5 second mark negative
        13'b011_10_01_100101,  // R6
        13'b101_01_10_010100,  // R7
        13'b000_00_00_000000   // R2
    };
    localparam int VREQ [0:NV-1] = '{2, 2, 3, 3, 4, 4, 5, 5, 6, 7, 2};

    function automatic logic [5:0] obs();
        return {line_pos, line_neg, line_rate_sel, rcv_pos, rcv_neg, rcv_clk_sel};
    endfunction

    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic r, input logic l, input logic o,
                         input logic [1:0] t, input logic te,
                         input logic [1:0] x, input logic xe);
        rmt_loop = r; loc_loop = l; ones_req = o;
        {tx_pos, tx_neg} = t; tx_en = te;
        {rx_pos, rx_neg} = x; rx_en = xe;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0);
        rst = 1'b0;
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        rmt_loop = 0; loc_loop = 0; ones_req = 0;
        tx_pos = 0; tx_neg = 0; tx_en = 0; rx_pos = 0; rx_neg = 0; rx_en = 0;
        @(negedge clk);
        do_reset();
        chk("R1", {obs(), loop_conflict}, 7'b0);

        for (int i = 0; i < NV; i++) begin
            drive(VT[i][12], VT[i][11], VT[i][10], VT[i][9:8], 1'b1, VT[i][7:6], 1'b1);
            chk($sformatf("R%0d vector %0d", VREQ[i], i),
                {obs(), loop_conflict}, {VT[i][5:0], 1'b0});
        end

        // R9: line follows tx_en, so an rx_en-only slot leaves it alone
        drive(1'b1, 1'b0, 1'b0, 2'b10, 1'b0, 2'b01, 1'b1);
        chk("R9 line hold", {obs(), loop_conflict}, 7'b000010_0);
        // R3: remote takes hold on the old transmit strobe
        drive(1'b1, 1'b0, 1'b0, 2'b10, 1'b1, 2'b01, 1'b0);
        chk("R3 switch", {obs(), loop_conflict}, 7'b011010_0);
        // R9: now timed by rx_en, a tx_en slot changes nothing
        drive(1'b1, 1'b0, 1'b0, 2'b01, 1'b1, 2'b10, 1'b0);
        chk("R9 remote hold", {obs(), loop_conflict}, 7'b011010_0);
        drive(1'b1, 1'b0, 1'b0, 2'b01, 1'b1, 2'b10, 1'b1);
        chk("R3 recovered slot", {obs(), loop_conflict}, 7'b101100_0);

        // R1 and R5: polarity restarts positive after reset
        do_reset();
        chk("R1 re-reset", {obs(), loop_conflict}, 7'b0);
        drive(1'b0, 1'b0, 1'b1, 2'b01, 1'b1, 2'b00, 1'b1);
        chk("R5 first mark", {obs(), loop_conflict}, 7'b100000_0);
        drive(1'b0, 1'b0, 1'b1, 2'b10, 1'b1, 2'b00, 1'b1);
        chk("R5 second mark", {obs(), loop_conflict}, 7'b010000_0);
        drive(1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 2'b00, 1'b1);
        chk("R9 ones hold", {obs(), loop_conflict}, 7'b010000_0);

        // R8: both loopbacks, local wins, flag sticks
        drive(1'b1, 1'b1, 1'b0, 2'b10, 1'b1, 2'b01, 1'b1);
        chk("R8 conflict", {obs(), loop_conflict}, 7'b100101_1);
        drive(1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 2'b00, 1'b1);
        chk("R8 sticky", {obs(), loop_conflict}, 7'b000000_1);
        do_reset();
        chk("R8 cleared by reset", {obs(), loop_conflict}, 7'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule